// File: doc/BRIEF.md
# Paired-Channel External Multiplexer Sequencer

This block steps a two-converter front end through up to sixteen analog inputs. The inputs sit behind two external 8:1 analog multiplexers that share one select bus. Inputs are converted in fixed pairs: pair k places input k on the first converter and input k+8 on the second, and both are sampled at the same moment. The sequencer drives the shared select bus, issues a one-cycle start pulse for each pair, and waits for one completion strobe shared by both converters. It then stores the two 12-bit results in a 32-entry result file. Software reads the file through a combinational read port.

As soon as a pair's conversion has been launched, the select bus moves on to the next enabled pair. The external multiplexers and the sample-and-hold stages then settle on the next pair while the current pair is still being converted. Each conversion raises a one-cycle end-of-conversion flag together with the lower result channel number. The last enabled pair of a pass also raises an end-of-sequence flag, and the sequencer then begins the next pass.

Three write-only registers set the behaviour: a control word, a pair-enable mask and an acquisition length. All three are sampled once, when a pass begins.

Top module: `pmx_seq`

## Requirements
- R1: A synchronous reset clears all 32 result entries to zero and the three registers to zero. After reset, muxAddr is 0 and convStart, eoc and eos are all low.
- R2: With the enable bit (control word bit 8) clear, or with no pair enabled, the sequencer stays idle and raises none of convStart, eoc or eos.
- R3: Only bits 7:0 of the pair-enable register (select 1) count, with bit k enabling pair k. Bits 15:8 have no effect.
- R4: muxAddr carries the pair index in bits 2:0, and bits 4:3 are always 0.
- R5: convStart is high for exactly one cycle. In the cycle after it, muxAddr shows the next enabled pair of the current pass, or keeps its value if the launched pair is the last one of the pass.
- R6: The acquisition length is L = max(register select 2, bits 7:0; 4). convStart rises L cycles after muxAddr takes a new pair, or later if the previous pair's results have not yet arrived.
- R7: A completion (convDone high while a pair is in flight) writes resA to entry (B+k) mod 32 and resB to entry (B+k+8) mod 32. Here B is control word bits 4:0 and k is the pair. With B = 16, pair k lands in entries 16+k and 24+k.
- R8: eoc pulses for one cycle in the cycle after the completion is sampled, and chanOut then shows (B+k) mod 32.
- R9: The completion of the last enabled pair raises eos together with eoc. The next pass then starts again at the lowest enabled pair, with muxAddr changing two cycles after that completion.
- R10: Register writes made during a pass do not affect that pass. They take effect at the start of the next pass.
- R11: Disabled pairs are skipped. They are never placed on muxAddr for conversion and never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWr | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 control, 1 pair enable, 2 acquisition length |
| regWrData | input | 16 | Register write data |
| rdChan | input | 5 | Result file read index |
| rdData | output | 12 | Result at rdChan (combinational) |
| muxAddr | output | 5 | Select bus to the external multiplexers |
| convStart | output | 1 | One-cycle conversion start for both converters |
| convDone | input | 1 | Shared completion strobe from the converters |
| resA | input | 12 | Result of the first converter (input k) |
| resB | input | 12 | Result of the second converter (input k+8) |
| eoc | output | 1 | End-of-conversion pulse |
| eos | output | 1 | End-of-sequence pulse |
| chanOut | output | 5 | Lower result channel of the pair just written |

## Verification
Two things can fall on the same clock edge: the storage of pair k's results with its eoc, and the move of the select bus to pair k+1. The bench provokes this with a converter model whose completion arrives one cycle after the start pulse, so that both events land on the same edge. A second collision is a register write arriving while a pass is running, close to its end-of-sequence. The behavioural model predicts muxAddr, convStart, eoc, eos and chanOut for every cycle, and every cycle is compared against it. Targeted checks additionally judge the pass order, the start-to-start spacing and the result-file placement against values worked out from the requirements.

// File: rtl/pmx_pkg.sv
package pmx_pkg;

  // Result file index width (32 result channels)
  localparam int CH_W = 5;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic            wrRes;
    logic [CH_W-1:0] loChan;
    logic [CH_W-1:0] hiChan;
  } pmx_strobe_t;

endpackage

// File: rtl/pmx_ctrl.sv
module pmx_ctrl
  import pmx_pkg::*;
#(
  parameter int NPAIR  = 8,
  parameter int ACQW   = 8,
  parameter int MINACQ = 4
)(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfgMuxEn,
  input  logic [CH_W-1:0]            cfgBase,
  input  logic [NPAIR-1:0]           cfgPairEn,
  input  logic [ACQW-1:0]            cfgAcq,
  input  logic                       convDone,
  output logic                       convStart,
  output logic [$clog2(NPAIR)-1:0]   muxSel,
  output logic                       eoc,
  output logic                       eos,
  output logic [CH_W-1:0]            chanOut,
  output pmx_strobe_t                stb
);

  localparam int PW = $clog2(NPAIR);

  seq_state_t       state;
  logic [NPAIR-1:0] passEn;
  logic [CH_W-1:0]  passBase;
  logic [ACQW-1:0]  passAcq;
  logic [ACQW-1:0]  acqCnt;
  logic [ACQW-1:0]  acqEff;
  logic [PW-1:0]    muxQ;
  logic [PW-1:0]    busyPair;
  logic [PW-1:0]    nextQ;
  logic             acqValid;
  logic             busy;
  logic             busyLast;
  logic             advPend;
  logic [PW:0]      firstHit;
  logic [PW:0]      nextHit;
  logic             startNow;
  logic             doneNow;

  // Lowest set bit of mask at or above lo: {found, index}
  function automatic logic [PW:0] findFrom(input logic [NPAIR-1:0] mask, input int lo);
    logic [PW:0] r = '0;
    for (int i = NPAIR - 1; i >= 0; i--) begin
      if (i >= lo && mask[i]) r = {1'b1, PW'(i)};
    end
    return r;
  endfunction

  assign acqEff   = (cfgAcq < ACQW'(MINACQ)) ? ACQW'(MINACQ) : cfgAcq;
  assign firstHit = findFrom(cfgPairEn, 0);
  assign nextHit  = findFrom(passEn, int'(muxQ) + 1);
  assign startNow = (state == ST_RUN) && acqValid && (acqCnt == '0) && !busy;
  assign doneNow  = (state == ST_RUN) && busy && convDone;

  assign stb.wrRes  = doneNow;
  assign stb.loChan = passBase + CH_W'(busyPair);
  assign stb.hiChan = passBase + CH_W'(busyPair) + CH_W'(NPAIR);
  assign muxSel     = muxQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      passEn    <= '0;
      passBase  <= '0;
      passAcq   <= '0;
      acqCnt    <= '0;
      muxQ      <= '0;
      busyPair  <= '0;
      nextQ     <= '0;
      acqValid  <= 1'b0;
      busy      <= 1'b0;
      busyLast  <= 1'b0;
      advPend   <= 1'b0;
      convStart <= 1'b0;
      eoc       <= 1'b0;
      eos       <= 1'b0;
      chanOut   <= '0;
    end else begin
      convStart <= 1'b0;
      eoc       <= 1'b0;
      eos       <= 1'b0;
      advPend   <= 1'b0;
      if (state == ST_IDLE) begin
        // Pass start: snapshot the configuration
        if (cfgMuxEn && firstHit[PW]) begin
          passEn   <= cfgPairEn;
          passBase <= cfgBase;
          passAcq  <= acqEff;
          muxQ     <= firstHit[PW-1:0];
          acqCnt   <= acqEff - ACQW'(1);
          acqValid <= 1'b1;
          busy     <= 1'b0;
          state    <= ST_RUN;
        end
      end else begin
        if (acqCnt != '0) acqCnt <= acqCnt - ACQW'(1);
        // One cycle after the start pulse: move the select bus on
        if (advPend && !busyLast) begin
          muxQ     <= nextQ;
          acqCnt   <= passAcq - ACQW'(1);
          acqValid <= 1'b1;
        end
        if (doneNow) begin
          eoc     <= 1'b1;
          chanOut <= passBase + CH_W'(busyPair);
          busy    <= 1'b0;
          if (busyLast) begin
            eos   <= 1'b1;
            state <= ST_IDLE;
          end
        end
        if (startNow) begin
          convStart <= 1'b1;
          busy      <= 1'b1;
          busyPair  <= muxQ;
          busyLast  <= !nextHit[PW];
          nextQ     <= nextHit[PW-1:0];
          acqValid  <= 1'b0;
          advPend   <= 1'b1;
        end
      end
    end
  end

  // R5: the start strobe is a single-cycle pulse
  p_start_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    convStart |=> !convStart);

  // R6: the select bus has been steady through the cycle that launches
  p_mux_settled_r6: assert property (@(posedge clk) disable iff (rst)
    convStart |-> $stable(muxQ));

  // R6: a pair is launched only when no conversion was in flight
  p_start_when_free_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(convStart) |-> !$past(busy));

  // R9: end of sequence only accompanies an end of conversion
  p_eos_with_eoc_r9: assert property (@(posedge clk) disable iff (rst)
    eos |-> eoc);

  // R8: end of conversion is a single-cycle pulse
  p_eoc_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    eoc |=> !eoc);

  // R2: nothing starts while the sequencer is idle
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !convStart);

endmodule

// File: rtl/pmx_dpath.sv
module pmx_dpath
  import pmx_pkg::*;
#(
  parameter int NPAIR = 8,
  parameter int DW    = 12,
  parameter int ACQW  = 8,
  parameter int REGW  = 16
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              regWr,
  input  logic [1:0]        regSel,
  input  logic [REGW-1:0]   regWrData,
  input  logic [CH_W-1:0]   rdChan,
  output logic [DW-1:0]     rdData,
  input  logic [DW-1:0]     resA,
  input  logic [DW-1:0]     resB,
  input  pmx_strobe_t       stb,
  output logic              cfgMuxEn,
  output logic [CH_W-1:0]   cfgBase,
  output logic [NPAIR-1:0]  cfgPairEn,
  output logic [ACQW-1:0]   cfgAcq
);

  localparam int NCHAN     = 1 << CH_W;
  localparam int MUXEN_BIT = 8;

  logic [DW-1:0] resFile [NCHAN];
  logic          unusedHi;

  assign unusedHi = ^regWrData[REGW-1:MUXEN_BIT+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCHAN; i++) resFile[i] <= '0;
      cfgMuxEn  <= 1'b0;
      cfgBase   <= '0;
      cfgPairEn <= '0;
      cfgAcq    <= '0;
    end else begin
      if (regWr) begin
        case (regSel)
          2'd0: begin
            cfgBase  <= regWrData[CH_W-1:0];
            cfgMuxEn <= regWrData[MUXEN_BIT];
          end
          2'd1:    cfgPairEn <= regWrData[NPAIR-1:0];
          2'd2:    cfgAcq    <= regWrData[ACQW-1:0];
          default: ;
        endcase
      end
      if (stb.wrRes) begin
        resFile[stb.loChan] <= resA;
        resFile[stb.hiChan] <= resB;
      end
    end
  end

  assign rdData = resFile[rdChan];

  // R7: the two entries of one completion lie one bank of pairs apart
  p_pair_spacing_r7: assert property (@(posedge clk) disable iff (rst)
    stb.wrRes |-> (stb.hiChan == stb.loChan + CH_W'(NPAIR)));

endmodule

// File: rtl/pmx_seq.sv
module pmx_seq
  import pmx_pkg::*;
#(
  parameter int NPAIR  = 8,
  parameter int DW     = 12,
  parameter int ACQW   = 8,
  parameter int MINACQ = 4,
  parameter int REGW   = 16
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             regWr,
  input  logic [1:0]       regSel,
  input  logic [REGW-1:0]  regWrData,
  input  logic [CH_W-1:0]  rdChan,
  output logic [DW-1:0]    rdData,
  output logic [CH_W-1:0]  muxAddr,
  output logic             convStart,
  input  logic             convDone,
  input  logic [DW-1:0]    resA,
  input  logic [DW-1:0]    resB,
  output logic             eoc,
  output logic             eos,
  output logic [CH_W-1:0]  chanOut
);

  logic                     cfgMuxEn;
  logic [CH_W-1:0]          cfgBase;
  logic [NPAIR-1:0]         cfgPairEn;
  logic [ACQW-1:0]          cfgAcq;
  logic [$clog2(NPAIR)-1:0] muxSel;
  pmx_strobe_t              stb;

  pmx_ctrl #(.NPAIR(NPAIR), .ACQW(ACQW), .MINACQ(MINACQ)) u_ctrl (
    .clk(clk), .rst(rst),
    .cfgMuxEn(cfgMuxEn), .cfgBase(cfgBase), .cfgPairEn(cfgPairEn), .cfgAcq(cfgAcq),
    .convDone(convDone), .convStart(convStart), .muxSel(muxSel),
    .eoc(eoc), .eos(eos), .chanOut(chanOut), .stb(stb)
  );

  pmx_dpath #(.NPAIR(NPAIR), .DW(DW), .ACQW(ACQW), .REGW(REGW)) u_dpath (
    .clk(clk), .rst(rst),
    .regWr(regWr), .regSel(regSel), .regWrData(regWrData),
    .rdChan(rdChan), .rdData(rdData), .resA(resA), .resB(resB), .stb(stb),
    .cfgMuxEn(cfgMuxEn), .cfgBase(cfgBase), .cfgPairEn(cfgPairEn), .cfgAcq(cfgAcq)
  );

  assign muxAddr = CH_W'(muxSel);

endmodule

// File: tb/sim_pmx_seq.sv
module sim_pmx_seq;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic        regWr = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [15:0] regWrData = 16'd0;
  logic [4:0]  rdChan = 5'd0;
  logic [11:0] rdData;
  logic [4:0]  muxAddr;
  logic        convStart;
  logic        convDone = 1'b0;
  logic [11:0] resA = 12'd0;
  logic [11:0] resB = 12'd0;
  logic        eoc;
  logic        eos;
  logic [4:0]  chanOut;

  pmx_seq u0 (
    .clk(clk), .rst(rst), .regWr(regWr), .regSel(regSel), .regWrData(regWrData),
    .rdChan(rdChan), .rdData(rdData), .muxAddr(muxAddr), .convStart(convStart),
    .convDone(convDone), .resA(resA), .resB(resB), .eoc(eoc), .eos(eos), .chanOut(chanOut)
  );

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  bit wdFired = 1'b0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- converter responder ----------------
  int lat = 1;
  int rspCnt = 0;
  int rspPair = 0;
  int rspTag = 0;

  always @(negedge clk) begin
    convDone = 1'b0;
    if (convStart === 1'b1) begin
      rspCnt  = lat;
      rspPair = int'(muxAddr);
    end
    if (rspCnt > 0) begin
      rspCnt--;
      if (rspCnt == 0) begin
        rspTag++;
        convDone = 1'b1;
        resA = 12'(((rspTag & 255) << 4) | rspPair);
        resB = 12'(((rspTag & 255) << 4) | rspPair | 8);
      end
    end
  end

  // ---------------- behavioural reference model ----------------
  int mCfgEn, mCfgBase, mCfgMux, mCfgAcq;
  int mState, mPassEn, mPassBase, mPassAcq;
  int mMux, mCnt, mValid, mBusy, mBusyPair, mBusyLast, mNext, mAdv;
  int mStart, mEoc, mEos, mCh;
  int mRes [32];

  function automatic int lowFrom(int m, int lo);
    for (int i = lo; i < 8; i++) if (((m >> i) & 1) != 0) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    int first, nx, clampA;
    bit st, dn, adv;
    cyc++;
    if (rst) begin
      mCfgEn = 0; mCfgBase = 0; mCfgMux = 0; mCfgAcq = 0;
      mState = 0; mPassEn = 0; mPassBase = 0; mPassAcq = 4;
      mMux = 0; mCnt = 0; mValid = 0; mBusy = 0; mBusyPair = 0;
      mBusyLast = 0; mNext = 0; mAdv = 0;
      mStart = 0; mEoc = 0; mEos = 0; mCh = 0;
      for (int i = 0; i < 32; i++) mRes[i] = 0;
    end else begin
      st  = (mState == 1) && (mValid != 0) && (mCnt == 0) && (mBusy == 0);
      dn  = (mState == 1) && (mBusy != 0) && (convDone == 1'b1);
      adv = (mAdv != 0);
      mStart = 0; mEoc = 0; mEos = 0; mAdv = 0;
      if (mState == 0) begin
        first = lowFrom(mCfgEn, 0);
        if (mCfgMux != 0 && first >= 0) begin
          clampA = (mCfgAcq < 4) ? 4 : mCfgAcq;
          mPassEn = mCfgEn; mPassBase = mCfgBase; mPassAcq = clampA;
          mMux = first; mCnt = clampA - 1; mValid = 1; mBusy = 0; mState = 1;
        end
      end else begin
        if (mCnt > 0) mCnt--;
        if (adv && mBusyLast == 0) begin
          mMux = mNext; mCnt = mPassAcq - 1; mValid = 1;
        end
        if (dn) begin
          mRes[(mPassBase + mBusyPair) % 32]     = int'(resA);
          mRes[(mPassBase + mBusyPair + 8) % 32] = int'(resB);
          mEoc = 1; mCh = (mPassBase + mBusyPair) % 32; mBusy = 0;
          if (mBusyLast != 0) begin mEos = 1; mState = 0; end
        end
        if (st) begin
          nx = lowFrom(mPassEn, mMux + 1);
          mStart = 1; mBusy = 1; mBusyPair = mMux;
          mBusyLast = (nx < 0) ? 1 : 0; mNext = (nx < 0) ? 0 : nx;
          mValid = 0; mAdv = 1;
        end
      end
      if (regWr) begin
        case (regSel)
          2'd0: begin mCfgBase = int'(regWrData) & 31; mCfgMux = (int'(regWrData) >> 8) & 1; end
          2'd1: mCfgEn = int'(regWrData) & 255;
          2'd2: mCfgAcq = int'(regWrData) & 255;
          default: ;
        endcase
      end
    end
    if (cyc > 150000 && !wdFired) begin
      wdFired = 1'b1;
      checks++;
      errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (cyc > 0 && !wdFired) begin
      chk("R5 muxAddr vs model", int'(muxAddr), mMux);
      chk("R4 muxAddr upper bits", int'(muxAddr[4:3]), 0);
      chk("R6 convStart vs model", int'(convStart), mStart);
      chk("R8 eoc vs model", int'(eoc), mEoc);
      if (mEoc != 0) chk("R8 chanOut vs model", int'(chanOut), mCh);
      chk("R9 eos vs model", int'(eos), mEos);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wrReg(int sel, int val);
    @(negedge clk);
    regWr = 1'b1; regSel = 2'(sel); regWrData = 16'(val);
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic setCfg(int en, int base);
    wrReg(0, (en << 8) | base);
  endtask

  task automatic drain(int base);
    setCfg(0, base);
    repeat (300) @(negedge clk);
  endtask

  task automatic nextEoc(output int ch, output int e);
    do @(negedge clk); while (eoc !== 1'b1);
    ch = int'(chanOut);
    e  = int'(eos);
  endtask

  task automatic quietCount(int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (convStart === 1'b1 || eoc === 1'b1 || eos === 1'b1) cnt++;
    end
  endtask

  initial begin
    int ch, e, g, cnt;
    int expCh[4];
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 convStart after reset", int'(convStart), 0);
    chk("R1 eoc after reset", int'(eoc), 0);
    chk("R1 eos after reset", int'(eos), 0);
    chk("R1 muxAddr after reset", int'(muxAddr), 0);
    for (int i = 0; i < 32; i++) begin
      rdChan = 5'(i); #1;
      chk("R1 result cleared", int'(rdData), 0);
    end

    // R2: pairs enabled but enable bit clear; then enable bit set, no pairs
    wrReg(1, 'hFF);
    wrReg(2, 0);
    setCfg(0, 16);
    quietCount(40, cnt);
    chk("R2 idle with enable bit clear", cnt, 0);
    wrReg(1, 0);
    setCfg(1, 16);
    quietCount(40, cnt);
    chk("R2 idle with no pair enabled", cnt, 0);

    // R3: only upper enable bits set -> still idle
    wrReg(1, 'hFF00);
    quietCount(40, cnt);
    chk("R3 upper enable bits ignored", cnt, 0);

    // R3/R5/R6/R8: pairs 0,1 (upper bits junk), acq 2 -> clamped to 4, completion one cycle after start
    setCfg(0, 16);
    wrReg(2, 2);
    lat = 1;
    wrReg(1, 'hFF03);
    setCfg(1, 16);
    do @(negedge clk); while (convStart !== 1'b1);
    chk("R3 first pair with junk upper bits", int'(muxAddr), 0);
    @(negedge clk);
    chk("R5 select moves one cycle after start", int'(muxAddr), 1);
    chk("R8 eoc in the same cycle as select move", int'(eoc), 1);
    chk("R8 chanOut of pair 0", int'(chanOut), 16);
    g = 1;
    do begin @(negedge clk); g++; end while (convStart !== 1'b1);
    chk("R6 start spacing with clamped length", g, 5);

    // R10: new acquisition length applies from a later pass
    wrReg(2, 6);
    cnt = 0;
    while (cnt < 2) begin nextEoc(ch, e); if (e != 0) cnt++; end
    do @(negedge clk); while (convStart !== 1'b1);
    g = 0;
    do begin @(negedge clk); g++; end while (convStart !== 1'b1);
    chk("R10 R6 start spacing after pass boundary", g, 7);

    // R11/R9: sparse mask 0xA5 with slow converter
    drain(16);
    wrReg(1, 'hA5);
    wrReg(2, 6);
    lat = 8;
    setCfg(1, 16);
    expCh[0] = 16; expCh[1] = 18; expCh[2] = 21; expCh[3] = 23;
    for (int i = 0; i < 4; i++) begin
      nextEoc(ch, e);
      chk("R11 pass order skips disabled pairs", ch, expCh[i]);
      chk("R9 eos only on last pair", e, (i == 3) ? 1 : 0);
    end
    nextEoc(ch, e);
    chk("R9 wrap to first enabled pair", ch, 16);

    // R10: mask change mid-pass
    drain(16);
    wrReg(1, 'h0F);
    wrReg(2, 4);
    lat = 3;
    setCfg(1, 16);
    nextEoc(ch, e);
    chk("R10 first pair of pass", ch, 16);
    wrReg(1, 'hF0);
    expCh[0] = 17; expCh[1] = 18; expCh[2] = 19; expCh[3] = 20;
    for (int i = 0; i < 4; i++) begin
      nextEoc(ch, e);
      chk("R10 old mask holds until pass end", ch, expCh[i]);
      chk("R10 eos at old pass end", e, (i == 2) ? 1 : 0);
    end

    // R7: result file against model, then base wrap placement
    drain(16);
    for (int i = 0; i < 32; i++) begin
      rdChan = 5'(i); #1;
      chk("R7 result file contents", int'(rdData), mRes[i]);
    end
    rdChan = 5'd16; #1;
    chk("R7 pair 0 first result nonzero", (rdData != 0) ? 1 : 0, 1);
    setCfg(0, 28);
    wrReg(1, 'h20);
    setCfg(1, 28);
    nextEoc(ch, e);
    chk("R7 R8 wrapped lower channel", ch, 1);
    chk("R9 single pair is last", e, 1);
    rdChan = 5'd1; #1;
    chk("R7 first converter entry", int'(rdData) & 15, 5);
    rdChan = 5'd9; #1;
    chk("R7 second converter entry", int'(rdData) & 15, 13);

    // R1: reset while running clears results
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 32; i++) begin
      rdChan = 5'(i); #1;
      chk("R1 result cleared after run", int'(rdData), 0);
    end
    quietCount(30, cnt);
    chk("R1 R2 idle after reset", cnt, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule